// File: doc/BRIEF.md
# BCD Calendar Counter with Alarm

This block keeps the time of day and the calendar date and moves it forward by one second on each one-second strobe. It holds seconds, minutes, hours, day of week, day of month, month and a two-digit year. The leap-year rule uses a full year, formed by adding the two-digit year to a century base parameter. Mode inputs choose how each field appears on the register-side outputs: packed BCD or plain binary, and 24-hour or 12-hour format with a PM flag. A host load strobe writes a complete new time, given in the current encoding.

Each accepted second tick does three things. It advances the internal count and raises update-in-progress. It then waits a fixed number of timebase strobes. At the end of that wait it refreshes the register view, tests the hour, minute and second alarm bytes against the new time, and emits an update-ended pulse. If the alarm is enabled and matches, an alarm pulse goes out in the same cycle. A three-bit oscillator control field must hold the run code, or second ticks are ignored.

Top module: `rtc_calendar`

## Requirements
- R1: Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and start a new day.
- R2: Day of week counts 1 to 7 and goes from 7 back to 1 on each new day.
- R3: Month lengths are 31,28,31,30,31,30,31,31,30,31,30,31 for months 1 to 12. February has 29 days when the full year (BASE_YEAR + two-digit year) is divisible by 4 and is either not divisible by 100 or divisible by 400. With BASE_YEAR 2000, years 00 and 24 are leap and 23 is not.
- R4: When the day of month passes the month length it becomes 1 and the month increments. Month 12 rolls to 1 and increments the year, which wraps from 99 to 00.
- R5: With bin_mode=0, every field is BCD: the tens digit is in bits 7:4 and the units digit in bits 3:0. With bin_mode=1, every field is the plain binary value. Load inputs are decoded with the same rule.
- R6: With h24_mode=0, the hour output holds hour mod 12 in bits 6:0, and bit 7 is set for hours 12 to 23. On load in this mode, a set bit 7 adds 12 to the decoded 7-bit hour.
- R7: A sec_tick advances time only when osc_sel equals 3'b010. Any other value makes the tick have no effect.
- R8: After an accepted tick, uip is high from the next cycle. The register view keeps its old value until DELAY_TICKS tb_tick strobes have been counted. It then refreshes, upd_end pulses for exactly one cycle, and uip falls in that same cycle. A sec_tick that arrives during an update is ignored.
- R9: While set_mode is 1, an accepted tick still advances the internal count and still produces upd_end. It does not raise uip and does not refresh the register view.
- R10: At the end of an update, each alarm byte matches if bits 7:6 are 2'b11 (wildcard) or if its decoded value equals the current field. The hour byte is decoded with the R6 rule. alarm_hit pulses with upd_end only when all three bytes match and alarm_en is 1.
- R11: ld_stb replaces all seven fields in one cycle, and the new values appear on the outputs in the next cycle. A sec_tick in the same cycle as ld_stb is ignored.
- R12: A change of bin_mode or h24_mode re-encodes the outputs at once, without an update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; time becomes 00:00:00, weekday 1, 01/01/00 |
| sec_tick | input | 1 | One-second strobe |
| tb_tick | input | 1 | Timebase strobe that paces the update delay |
| osc_sel | input | 3 | Oscillator control; 3'b010 lets time run |
| bin_mode | input | 1 | 1 = binary fields, 0 = BCD fields |
| h24_mode | input | 1 | 1 = 24-hour, 0 = 12-hour with PM at bit 7 |
| set_mode | input | 1 | Freezes the register view and suppresses uip |
| alarm_en | input | 1 | Enables alarm_hit |
| ld_stb | input | 1 | Loads all ld_* fields |
| ld_sec | input | 8 | Seconds to load |
| ld_min | input | 8 | Minutes to load |
| ld_hour | input | 8 | Hours to load |
| ld_dow | input | 8 | Day of week to load |
| ld_dom | input | 8 | Day of month to load |
| ld_mon | input | 8 | Month to load |
| ld_year | input | 8 | Two-digit year to load |
| alm_sec | input | 8 | Second alarm byte |
| alm_min | input | 8 | Minute alarm byte |
| alm_hour | input | 8 | Hour alarm byte |
| rd_sec | output | 8 | Seconds, encoded |
| rd_min | output | 8 | Minutes, encoded |
| rd_hour | output | 8 | Hours, encoded |
| rd_dow | output | 8 | Day of week, encoded |
| rd_dom | output | 8 | Day of month, encoded |
| rd_mon | output | 8 | Month, encoded |
| rd_year | output | 8 | Year, encoded |
| uip | output | 1 | Update in progress |
| upd_end | output | 1 | One-cycle update-ended pulse |
| alarm_hit | output | 1 | One-cycle alarm pulse |

## Verification
The assertions cover the cycle-level rules on every cycle. An advance never happens without the run code and never happens alongside a load. upd_end lasts one cycle, follows the internal refresh event, and coincides with uip low. uip never rises while set mode is on. alarm_hit never fires without enable or outside an update end. Only the bench scenarios can show the arithmetic: the carries through minutes, hours, days, months and years, leap and non-leap February, BCD versus binary and 12-hour versus 24-hour images, and the decoding of alarm bytes including the wildcard.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  typedef struct packed {
    logic [6:0] sec;
    logic [6:0] min;
    logic [6:0] hour;
    logic [6:0] dow;
    logic [6:0] dom;
    logic [6:0] mon;
    logic [6:0] year;
  } cal_t;

  localparam cal_t CAL_RESET = '{sec: 7'd0, min: 7'd0, hour: 7'd0, dow: 7'd1,
                                 dom: 7'd1, mon: 7'd1, year: 7'd0};

  // binary value to register image
  function automatic logic [7:0] to_reg(input logic [6:0] v, input logic bin);
    logic [6:0] t;
    logic [6:0] u;
    t = v / 7'd10;
    u = v - t * 7'd10;
    return bin ? {1'b0, v} : {t[3:0], u[3:0]};
  endfunction

  // register image to binary value
  function automatic logic [6:0] from_reg(input logic [7:0] r, input logic bin);
    logic [6:0] t;
    t = {3'b000, r[7:4]};
    return bin ? r[6:0] : (t * 7'd10 + {3'b000, r[3:0]});
  endfunction

  function automatic logic [7:0] hour_to_reg(input logic [6:0] h, input logic bin,
                                             input logic h24);
    logic       pm;
    logic [6:0] hh;
    logic [7:0] r;
    pm = (h >= 7'd12);
    hh = pm ? h - 7'd12 : h;
    r  = to_reg(hh, bin);
    return h24 ? to_reg(h, bin) : {pm, r[6:0]};
  endfunction

  function automatic logic [6:0] hour_from_reg(input logic [7:0] r, input logic bin,
                                               input logic h24);
    logic [6:0] h;
    h = from_reg({1'b0, r[6:0]}, bin);
    if (!h24 && r[7]) h = h + 7'd12;
    return h;
  endfunction

  function automatic logic is_leap(input logic [6:0] yy, input int base);
    int full;
    full = base + int'(yy);
    return (full % 4 == 0) && ((full % 100 != 0) || (full % 400 == 0));
  endfunction

  function automatic logic [6:0] month_len(input logic [6:0] mon, input logic [6:0] yy,
                                           input int base);
    case (mon)
      7'd2:                       return is_leap(yy, base) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:    return 7'd30;
      default:                    return 7'd31;
    endcase
  endfunction

  function automatic cal_t next_second(input cal_t c, input int base);
    cal_t n;
    n = c;
    if (c.sec >= 7'd59) begin
      n.sec = 7'd0;
      if (c.min >= 7'd59) begin
        n.min = 7'd0;
        if (c.hour >= 7'd23) begin
          n.hour = 7'd0;
          n.dow  = (c.dow >= 7'd7) ? 7'd1 : c.dow + 7'd1;
          if (c.dom >= month_len(c.mon, c.year, base)) begin
            n.dom = 7'd1;
            if (c.mon >= 7'd12) begin
              n.mon  = 7'd1;
              n.year = (c.year >= 7'd99) ? 7'd0 : c.year + 7'd1;
            end else begin
              n.mon = c.mon + 7'd1;
            end
          end else begin
            n.dom = c.dom + 7'd1;
          end
        end else begin
          n.hour = c.hour + 7'd1;
        end
      end else begin
        n.min = c.min + 7'd1;
      end
    end else begin
      n.sec = c.sec + 7'd1;
    end
    return n;
  endfunction

endpackage

// File: rtl/rtc_cal_counter.sv
module rtc_cal_counter
  import rtc_cal_pkg::*;
#(
  parameter int BASE_YEAR = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_en,
  input  cal_t load_val,
  input  logic step_en,
  output cal_t cur
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cur <= CAL_RESET;
    else if (load_en) cur <= load_val;
    else if (step_en) cur <= next_second(cur, BASE_YEAR);
  end

endmodule

// File: rtl/rtc_upd_seq.sv
module rtc_upd_seq #(
  parameter int DELAY_TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tb_tick,
  input  logic set_mode,
  output logic busy,
  output logic finish,
  output logic uip,
  output logic upd_end
);

  localparam int CNT_W = (DELAY_TICKS > 1) ? $clog2(DELAY_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_TICKS - 1);

  logic [CNT_W-1:0] cnt;

  assign finish = busy && tb_tick && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      uip     <= 1'b0;
      upd_end <= 1'b0;
    end else begin
      upd_end <= finish;
      if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
        uip  <= !set_mode;
      end else if (finish) begin
        busy <= 1'b0;
        uip  <= 1'b0;
      end else if (busy && tb_tick) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_cal_pkg::*;
(
  input  cal_t       cur,
  input  logic [7:0] alm_sec,
  input  logic [7:0] alm_min,
  input  logic [7:0] alm_hour,
  input  logic       bin_mode,
  input  logic       h24_mode,
  output logic       match
);

  logic sec_ok, min_ok, hour_ok;

  always_comb begin
    sec_ok  = (alm_sec[7:6] == 2'b11)  || (from_reg(alm_sec, bin_mode) == cur.sec);
    min_ok  = (alm_min[7:6] == 2'b11)  || (from_reg(alm_min, bin_mode) == cur.min);
    hour_ok = (alm_hour[7:6] == 2'b11) ||
              (hour_from_reg(alm_hour, bin_mode, h24_mode) == cur.hour);
    match   = sec_ok && min_ok && hour_ok;
  end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int BASE_YEAR   = 2000,
  parameter int DELAY_TICKS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic       tb_tick,
  input  logic [2:0] osc_sel,
  input  logic       bin_mode,
  input  logic       h24_mode,
  input  logic       set_mode,
  input  logic       alarm_en,
  input  logic       ld_stb,
  input  logic [7:0] ld_sec,
  input  logic [7:0] ld_min,
  input  logic [7:0] ld_hour,
  input  logic [7:0] ld_dow,
  input  logic [7:0] ld_dom,
  input  logic [7:0] ld_mon,
  input  logic [7:0] ld_year,
  input  logic [7:0] alm_sec,
  input  logic [7:0] alm_min,
  input  logic [7:0] alm_hour,
  output logic [7:0] rd_sec,
  output logic [7:0] rd_min,
  output logic [7:0] rd_hour,
  output logic [7:0] rd_dow,
  output logic [7:0] rd_dom,
  output logic [7:0] rd_mon,
  output logic [7:0] rd_year,
  output logic       uip,
  output logic       upd_end,
  output logic       alarm_hit
);

  localparam logic [2:0] OSC_RUN  = 3'b010;
  localparam int         N_PLAIN  = 6;

  // named internal events
  logic osc_run;
  logic busy;
  logic advance_fire;
  logic refresh_fire;
  logic alarm_match;

  cal_t load_val;
  cal_t cur;
  cal_t snap;

  assign osc_run      = (osc_sel == OSC_RUN);
  assign advance_fire = sec_tick && osc_run && !busy && !ld_stb;

  always_comb begin
    load_val.sec  = from_reg(ld_sec, bin_mode);
    load_val.min  = from_reg(ld_min, bin_mode);
    load_val.hour = hour_from_reg(ld_hour, bin_mode, h24_mode);
    load_val.dow  = from_reg(ld_dow, bin_mode);
    load_val.dom  = from_reg(ld_dom, bin_mode);
    load_val.mon  = from_reg(ld_mon, bin_mode);
    load_val.year = from_reg(ld_year, bin_mode);
  end

  rtc_cal_counter #(.BASE_YEAR(BASE_YEAR)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (ld_stb),
    .load_val (load_val),
    .step_en  (advance_fire),
    .cur      (cur)
  );

  rtc_upd_seq #(.DELAY_TICKS(DELAY_TICKS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (advance_fire),
    .tb_tick  (tb_tick),
    .set_mode (set_mode),
    .busy     (busy),
    .finish   (refresh_fire),
    .uip      (uip),
    .upd_end  (upd_end)
  );

  rtc_alarm_cmp u_alm (
    .cur      (cur),
    .alm_sec  (alm_sec),
    .alm_min  (alm_min),
    .alm_hour (alm_hour),
    .bin_mode (bin_mode),
    .h24_mode (h24_mode),
    .match    (alarm_match)
  );

  // register view: held time, re-encoded live from the mode inputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap      <= CAL_RESET;
      alarm_hit <= 1'b0;
    end else begin
      alarm_hit <= refresh_fire && alarm_en && alarm_match;
      if (ld_stb)                         snap <= load_val;
      else if (refresh_fire && !set_mode) snap <= cur;
    end
  end

  logic [6:0] plain_f   [N_PLAIN];
  logic [7:0] plain_enc [N_PLAIN];

  assign plain_f[0] = snap.sec;
  assign plain_f[1] = snap.min;
  assign plain_f[2] = snap.dow;
  assign plain_f[3] = snap.dom;
  assign plain_f[4] = snap.mon;
  assign plain_f[5] = snap.year;

  for (genvar i = 0; i < N_PLAIN; i++) begin : g_enc
    assign plain_enc[i] = to_reg(plain_f[i], bin_mode);
  end

  assign rd_sec  = plain_enc[0];
  assign rd_min  = plain_enc[1];
  assign rd_dow  = plain_enc[2];
  assign rd_dom  = plain_enc[3];
  assign rd_mon  = plain_enc[4];
  assign rd_year = plain_enc[5];
  assign rd_hour = hour_to_reg(snap.hour, bin_mode, h24_mode);

endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] osc_sel,
  input logic       set_mode,
  input logic       alarm_en,
  input logic       ld_stb,
  input logic       uip,
  input logic       upd_end,
  input logic       alarm_hit,
  input logic       advance_fire,
  input logic       refresh_fire
);

  a_r7_run_code_only: assert property (@(posedge clk) disable iff (!rst_n)
    advance_fire |-> (osc_sel == 3'b010));

  a_r11_load_beats_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stb |-> !advance_fire);

  a_r8_end_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    upd_end |=> !upd_end);

  a_r8_uip_low_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    upd_end |-> !uip);

  a_r8_end_after_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_fire |=> upd_end);

  a_r9_no_uip_in_set: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uip) |-> $past(!set_mode));

  a_r10_alarm_gated: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |-> (upd_end && $past(alarm_en)));

endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .osc_sel      (osc_sel),
  .set_mode     (set_mode),
  .alarm_en     (alarm_en),
  .ld_stb       (ld_stb),
  .uip          (uip),
  .upd_end      (upd_end),
  .alarm_hit    (alarm_hit),
  .advance_fire (advance_fire),
  .refresh_fire (refresh_fire)
);

// File: tb/rtc_calendar_tb.sv
module rtc_calendar_tb;

  localparam int DLY = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_tick = 1'b0, tb_tick = 1'b0;
  logic [2:0] osc_sel = 3'b010;
  logic bin_mode = 1'b0, h24_mode = 1'b1, set_mode = 1'b0, alarm_en = 1'b0;
  logic ld_stb = 1'b0;
  logic [7:0] ld_sec = 0, ld_min = 0, ld_hour = 0, ld_dow = 0, ld_dom = 0, ld_mon = 0, ld_year = 0;
  logic [7:0] alm_sec = 0, alm_min = 0, alm_hour = 0;
  logic [7:0] rd_sec, rd_min, rd_hour, rd_dow, rd_dom, rd_mon, rd_year;
  logic uip, upd_end, alarm_hit;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic uip_mid, end_seen, alm_seen, uip_end, end_gone;

  always #5 clk = ~clk;

  rtc_calendar u_dut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .tb_tick(tb_tick),
    .osc_sel(osc_sel), .bin_mode(bin_mode), .h24_mode(h24_mode),
    .set_mode(set_mode), .alarm_en(alarm_en), .ld_stb(ld_stb),
    .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour), .ld_dow(ld_dow),
    .ld_dom(ld_dom), .ld_mon(ld_mon), .ld_year(ld_year),
    .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour),
    .rd_sec(rd_sec), .rd_min(rd_min), .rd_hour(rd_hour), .rd_dow(rd_dow),
    .rd_dom(rd_dom), .rd_mon(rd_mon), .rd_year(rd_year),
    .uip(uip), .upd_end(upd_end), .alarm_hit(alarm_hit)
  );

  // expected encodings, restated from the requirements
  function automatic logic [7:0] enc(input int v);
    if (bin_mode) return 8'(v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [7:0] enc_hour(input int h);
    if (h24_mode) return enc(h);
    return enc(h % 12) | ((h >= 12) ? 8'h80 : 8'h00);
  endfunction

  task automatic chk(input string req, input string what, input logic [7:0] act,
                     input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic expect_view(input string req, input int s, input int m, input int h,
                             input int dw, input int dm, input int mo, input int yy);
    chk(req, "sec",  rd_sec,  enc(s));
    chk(req, "min",  rd_min,  enc(m));
    chk(req, "hour", rd_hour, enc_hour(h));
    chk(req, "dow",  rd_dow,  enc(dw));
    chk(req, "dom",  rd_dom,  enc(dm));
    chk(req, "mon",  rd_mon,  enc(mo));
    chk(req, "year", rd_year, enc(yy));
  endtask

  task automatic drive_load(input int s, input int m, input int h, input int dw,
                            input int dm, input int mo, input int yy);
    ld_sec = enc(s); ld_min = enc(m); ld_hour = enc_hour(h); ld_dow = enc(dw);
    ld_dom = enc(dm); ld_mon = enc(mo); ld_year = enc(yy);
    ld_stb = 1'b1;
  endtask

  task automatic load_time(input int s, input int m, input int h, input int dw,
                           input int dm, input int mo, input int yy);
    @(negedge clk);
    drive_load(s, m, h, dw, dm, mo, yy);
    @(negedge clk);
    ld_stb = 1'b0;
  endtask

  task automatic run_update();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    uip_mid = uip;
    for (int i = 0; i < DLY; i++) begin
      tb_tick = 1'b1;
      @(negedge clk);
      tb_tick = 1'b0;
    end
    end_seen = upd_end; alm_seen = alarm_hit; uip_end = uip;
    @(negedge clk);
    end_gone = !upd_end;
  endtask

  task automatic t_reset();
    expect_view("R5 reset", 0, 0, 0, 1, 1, 1, 0);
    chk("R8 reset", "uip", {7'd0, uip}, 8'd0);
    chk("R8 reset", "upd_end", {7'd0, upd_end}, 8'd0);
  endtask

  task automatic t_load();
    load_time(56, 34, 12, 3, 15, 6, 24);
    expect_view("R11 load", 56, 34, 12, 3, 15, 6, 24);
    chk("R5 bcd nibbles", "sec", rd_sec, 8'h56);
  endtask

  task automatic t_rollover();
    load_time(59, 59, 23, 7, 31, 12, 99);
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    chk("R8 uip rises", "uip", {7'd0, uip}, 8'd1);
    chk("R8 view held mid update", "sec", rd_sec, enc(59));
    for (int i = 0; i < DLY; i++) begin
      tb_tick = 1'b1; @(negedge clk); tb_tick = 1'b0;
    end
    chk("R8 end pulse", "upd_end", {7'd0, upd_end}, 8'd1);
    chk("R8 uip falls", "uip", {7'd0, uip}, 8'd0);
    expect_view("R1 R2 R4 year wrap", 0, 0, 0, 1, 1, 1, 0);
    @(negedge clk);
    chk("R8 pulse one cycle", "upd_end", {7'd0, upd_end}, 8'd0);
    load_time(59, 59, 10, 2, 5, 3, 10);
    run_update();
    expect_view("R1 minute carry", 0, 0, 11, 2, 5, 3, 10);
  endtask

  task automatic t_leap();
    load_time(59, 59, 23, 1, 28, 2, 24);
    run_update();
    expect_view("R3 leap 24", 0, 0, 0, 2, 29, 2, 24);
    load_time(59, 59, 23, 1, 28, 2, 23);
    run_update();
    expect_view("R3 non leap 23", 0, 0, 0, 2, 1, 3, 23);
    load_time(59, 59, 23, 4, 28, 2, 0);
    run_update();
    expect_view("R3 leap 2000", 0, 0, 0, 5, 29, 2, 0);
    load_time(59, 59, 23, 6, 30, 4, 23);
    run_update();
    expect_view("R4 30-day month", 0, 0, 0, 7, 1, 5, 23);
  endtask

  task automatic t_binary();
    @(negedge clk); bin_mode = 1'b1;
    @(negedge clk);
    chk("R12 live re-encode", "year", rd_year, 8'h17);
    chk("R12 live re-encode", "mon", rd_mon, 8'h05);
    load_time(59, 45, 20, 3, 31, 1, 42);
    chk("R5 binary load", "sec", rd_sec, 8'h3B);
    run_update();
    expect_view("R5 binary update", 0, 46, 20, 3, 31, 1, 42);
    @(negedge clk); bin_mode = 1'b0;
  endtask

  task automatic t_12h();
    @(negedge clk); h24_mode = 1'b0;
    load_time(0, 0, 13, 1, 1, 1, 1);
    chk("R6 pm flag", "hour", rd_hour, 8'h81);
    @(negedge clk); h24_mode = 1'b1;
    @(negedge clk);
    chk("R6 load adds 12", "hour", rd_hour, 8'h13);
    @(negedge clk); h24_mode = 1'b0;
    load_time(59, 59, 11, 1, 1, 1, 1);
    run_update();
    chk("R6 noon", "hour", rd_hour, 8'h80);
    @(negedge clk); h24_mode = 1'b1;
  endtask

  task automatic t_gate();
    load_time(10, 20, 5, 1, 1, 1, 1);
    @(negedge clk); osc_sel = 3'b110;
    run_update();
    chk("R7 gated uip", "uip", {7'd0, uip_mid}, 8'd0);
    chk("R7 gated end", "upd_end", {7'd0, end_seen}, 8'd0);
    chk("R7 gated view", "sec", rd_sec, enc(10));
    @(negedge clk); osc_sel = 3'b010;
  endtask

  task automatic t_busy();
    load_time(30, 0, 0, 1, 1, 1, 1);
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    for (int i = 0; i < DLY; i++) begin
      tb_tick = 1'b1;
      if (i == 3) sec_tick = 1'b1;
      @(negedge clk);
      tb_tick = 1'b0; sec_tick = 1'b0;
    end
    @(negedge clk);
    chk("R8 tick during update ignored", "sec", rd_sec, enc(31));
  endtask

  task automatic t_set();
    load_time(0, 0, 10, 1, 1, 1, 1);
    @(negedge clk); set_mode = 1'b1;
    run_update();
    chk("R9 no uip", "uip", {7'd0, uip_mid}, 8'd0);
    chk("R9 end still", "upd_end", {7'd0, end_seen}, 8'd1);
    chk("R9 view frozen", "sec", rd_sec, enc(0));
    @(negedge clk); set_mode = 1'b0;
    run_update();
    chk("R9 count kept running", "sec", rd_sec, enc(2));
  endtask

  task automatic t_alarm();
    @(negedge clk); alarm_en = 1'b1;
    alm_sec = 8'h15; alm_min = 8'h30; alm_hour = 8'h08;
    load_time(14, 30, 8, 1, 1, 1, 1);
    run_update();
    chk("R10 exact match", "alarm_hit", {7'd0, alm_seen}, 8'd1);
    alm_sec = 8'hC0; alm_min = 8'hFF;
    run_update();
    chk("R10 wildcard", "alarm_hit", {7'd0, alm_seen}, 8'd1);
    alm_hour = 8'h09;
    run_update();
    chk("R10 hour mismatch", "alarm_hit", {7'd0, alm_seen}, 8'd0);
    alm_hour = 8'hC0;
    @(negedge clk); alarm_en = 1'b0;
    run_update();
    chk("R10 disabled", "alarm_hit", {7'd0, alm_seen}, 8'd0);
    chk("R10 end while disabled", "upd_end", {7'd0, end_seen}, 8'd1);
  endtask

  task automatic t_collide();
    @(negedge clk);
    drive_load(40, 41, 2, 4, 9, 9, 9);
    sec_tick = 1'b1;
    @(negedge clk);
    ld_stb = 1'b0; sec_tick = 1'b0;
    chk("R11 tick dropped", "uip", {7'd0, uip}, 8'd0);
    expect_view("R11 load wins", 40, 41, 2, 4, 9, 9, 9);
    for (int i = 0; i < DLY; i++) begin
      tb_tick = 1'b1; @(negedge clk); tb_tick = 1'b0;
    end
    chk("R11 no update", "upd_end", {7'd0, upd_end}, 8'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_rollover();
    t_leap();
    t_binary();
    t_12h();
    t_gate();
    t_busy();
    t_set();
    t_alarm();
    t_collide();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule